// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit executes the second-byte opcode space of an 8-bit processor: 256 opcodes covering circular rotates, rotates through carry, arithmetic and logical shifts, nibble swap, single-bit test, single-bit clear and single-bit set. From the opcode byte alone it derives the operation, the bit index and the operand selector. It applies the operation to the 8-bit operand supplied by the surrounding datapath and returns the result, the new flag nibble and a write-back enable. It also reports which operand was addressed, whether that operand lives in memory, and how many clock ticks the instruction occupies. The sequencer uses these to fetch, write back and stretch timing.

The same datapath also serves the four one-byte accumulator rotate instructions. The core selects these with `acc_form`. They use the same rotate logic, but their zero flag is always cleared.

Register-file access and memory sequencing lie outside the unit. Every accepted request produces its outputs one clock later.

Top module: `bitop_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `wr_en`, `result`, `flags_out`, `src_sel`, `mem_operand` and `cycles` are all zero.
- R2: `out_valid` is `in_valid` delayed by one clock. When `in_valid` is low, `out_valid` and `wr_en` are low in the next cycle, and `result` and `flags_out` keep their previous values.
- R3: `src_sel` equals opcode bits 2:0, with the operand order B=0, C=1, D=2, E=3, H=4, L=5, memory-at-HL=6, A=7. `mem_operand` is 1 exactly when the selector is 6 and `acc_form` is 0.
- R4: When `acc_form` is 0, opcodes 0x00-0x1F are rotates, in steps of 8: circular left, circular right, left through carry, right through carry. Circular forms copy the bit shifted out into the vacated end. Through-carry forms shift in `flags_in` C. The flags are Z = (result==0), N=0, H=0, and C = the bit shifted out.
- R5: Opcodes 0x20-0x27 shift left and insert 0. Opcodes 0x28-0x2F shift right and keep bit 7. Opcodes 0x38-0x3F shift right and insert 0. The flags follow the same rule as R4.
- R6: Opcodes 0x30-0x37 exchange the two nibbles, with Z = (result==0) and N=H=C=0.
- R7: Opcodes 0x40-0x7F test bit `opcode[5:3]`. They set Z = NOT(tested bit), N=0, H=1, leave C equal to `flags_in` C, return the operand unchanged, and hold `wr_en` low.
- R8: Opcodes 0x80-0xBF clear bit `opcode[5:3]` and opcodes 0xC0-0xFF set it. `flags_out` equals `flags_in`.
- R9: With `acc_form`=1, `opcode[4:3]` selects the rotate from R4 in the same order, the operand is A (`src_sel`=7, `mem_operand`=0), Z is forced to 0, N=H=0, C is the bit shifted out, and `cycles`=4.
- R10: Without `acc_form`, `cycles` is 8 for a register operand and 16 for the memory operand, except a bit test on memory, which is 12.
- R11: `wr_en` is 1 for every valid request other than a bit test.
- R12: The flag nibble is Z in bit 3, N in bit 2, H in bit 1 and C in bit 0, on both `flags_in` and `flags_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| acc_form | input | 1 | Selects the one-byte accumulator rotate forms |
| opcode | input | 8 | Second opcode byte (or the one-byte rotate opcode when acc_form=1) |
| operand | input | 8 | Operand value fetched by the datapath |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Result valid |
| result | output | 8 | Operation result |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| wr_en | output | 1 | Write the result back to the selected operand |
| src_sel | output | 3 | Operand selector |
| mem_operand | output | 1 | Operand is memory at HL |
| cycles | output | 5 | Instruction duration in clock ticks |

## Verification
The assertions assume that `in_valid`, `acc_form` and `opcode` are driven to known values whenever the unit is out of reset, and that `flags_in` is stable alongside the request it belongs to. The flag-preservation property relies on this. The stimulus draws the opcode uniformly over all 256 codes and the operand and flags from `$urandom`, and raises `acc_form` on a fraction of requests. Each request is held for a full clock. Directed cases then exercise zero results, carry insertion, sign retention, and bit tests on memory.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int W   = 8;
    localparam int NIB = W / 2;

    typedef enum logic [3:0] {
        OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SWAP, OP_SRL,
        OP_BIT, OP_RES, OP_SET
    } op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        op_e        op;
        logic [2:0] idx;
        logic [2:0] sel;
        logic       mem;
        logic       acc;
    } dec_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int CYC_W        = 5,
    parameter int ACC_CYC      = 4,
    parameter int REG_CYC      = 8,
    parameter int MEM_CYC      = 16,
    parameter int MEM_TEST_CYC = 12
) (
    input  logic [7:0]       opcode,
    input  logic             acc_form,
    output dec_t             dec,
    output logic [CYC_W-1:0] cyc
);

    localparam logic [2:0] SEL_MEM = 3'd6;
    localparam logic [2:0] SEL_ACC = 3'd7;

    always_comb begin
        dec.idx = opcode[5:3];
        dec.acc = acc_form;
        if (acc_form) begin
            dec.sel = SEL_ACC;
            dec.mem = 1'b0;
            case (opcode[4:3])
                2'd0:    dec.op = OP_RLC;
                2'd1:    dec.op = OP_RRC;
                2'd2:    dec.op = OP_RL;
                default: dec.op = OP_RR;
            endcase
        end else begin
            dec.sel = opcode[2:0];
            dec.mem = (opcode[2:0] == SEL_MEM);
            case (opcode[7:6])
                2'd0: begin
                    case (opcode[5:3])
                        3'd0:    dec.op = OP_RLC;
                        3'd1:    dec.op = OP_RRC;
                        3'd2:    dec.op = OP_RL;
                        3'd3:    dec.op = OP_RR;
                        3'd4:    dec.op = OP_SLA;
                        3'd5:    dec.op = OP_SRA;
                        3'd6:    dec.op = OP_SWAP;
                        default: dec.op = OP_SRL;
                    endcase
                end
                2'd1:    dec.op = OP_BIT;
                2'd2:    dec.op = OP_RES;
                default: dec.op = OP_SET;
            endcase
        end

        if (dec.acc)
            cyc = CYC_W'(ACC_CYC);
        else if (!dec.mem)
            cyc = CYC_W'(REG_CYC);
        else if (dec.op == OP_BIT)
            cyc = CYC_W'(MEM_TEST_CYC);
        else
            cyc = CYC_W'(MEM_CYC);
    end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
(
    input  dec_t         dec,
    input  logic [W-1:0] operand,
    input  flags_t       flags_in,
    output logic [W-1:0] result,
    output flags_t       flags,
    output logic         wr
);

    logic shift_grp;
    logic out_bit;

    always_comb begin
        result    = operand;
        flags     = flags_in;
        wr        = 1'b1;
        shift_grp = 1'b1;
        out_bit   = 1'b0;
        case (dec.op)
            OP_RLC: begin
                result  = {operand[W-2:0], operand[W-1]};
                out_bit = operand[W-1];
            end
            OP_RRC: begin
                result  = {operand[0], operand[W-1:1]};
                out_bit = operand[0];
            end
            OP_RL: begin
                result  = {operand[W-2:0], flags_in.c};
                out_bit = operand[W-1];
            end
            OP_RR: begin
                result  = {flags_in.c, operand[W-1:1]};
                out_bit = operand[0];
            end
            OP_SLA: begin
                result  = {operand[W-2:0], 1'b0};
                out_bit = operand[W-1];
            end
            OP_SRA: begin
                result  = {operand[W-1], operand[W-1:1]};
                out_bit = operand[0];
            end
            OP_SRL: begin
                result  = {1'b0, operand[W-1:1]};
                out_bit = operand[0];
            end
            OP_SWAP: begin
                result  = {operand[NIB-1:0], operand[W-1:NIB]};
                out_bit = 1'b0;
            end
            OP_BIT: begin
                shift_grp = 1'b0;
                wr        = 1'b0;
                flags.z   = ~operand[dec.idx];
                flags.n   = 1'b0;
                flags.h   = 1'b1;
            end
            OP_RES: begin
                shift_grp           = 1'b0;
                result[dec.idx]     = 1'b0;
            end
            default: begin
                shift_grp           = 1'b0;
                result[dec.idx]     = 1'b1;
            end
        endcase

        if (shift_grp) begin
            flags.z = (result == '0) && !dec.acc;
            flags.n = 1'b0;
            flags.h = 1'b0;
            flags.c = out_bit;
        end
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int CYC_W        = 5,
    parameter int ACC_CYC      = 4,
    parameter int REG_CYC      = 8,
    parameter int MEM_CYC      = 16,
    parameter int MEM_TEST_CYC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             acc_form,
    input  logic [7:0]       opcode,
    input  logic [7:0]       operand,
    input  logic [3:0]       flags_in,
    output logic             out_valid,
    output logic [7:0]       result,
    output logic [3:0]       flags_out,
    output logic             wr_en,
    output logic [2:0]       src_sel,
    output logic             mem_operand,
    output logic [CYC_W-1:0] cycles
);

    typedef struct packed {
        logic             valid;
        logic [W-1:0]     result;
        flags_t           flags;
        logic             wr;
        logic [2:0]       sel;
        logic             mem;
        logic [CYC_W-1:0] cyc;
    } state_t;

    dec_t             dec;
    logic [CYC_W-1:0] dec_cyc;
    logic [W-1:0]     alu_res;
    flags_t           alu_flags;
    logic             alu_wr;
    state_t           st_d, st_q;

    bitop_decode #(
        .CYC_W(CYC_W), .ACC_CYC(ACC_CYC), .REG_CYC(REG_CYC),
        .MEM_CYC(MEM_CYC), .MEM_TEST_CYC(MEM_TEST_CYC)
    ) u_dec (
        .opcode   (opcode),
        .acc_form (acc_form),
        .dec      (dec),
        .cyc      (dec_cyc)
    );

    bitop_alu u_alu (
        .dec      (dec),
        .operand  (operand),
        .flags_in (flags_t'(flags_in)),
        .result   (alu_res),
        .flags    (alu_flags),
        .wr       (alu_wr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.wr    = 1'b0;
        if (in_valid) begin
            st_d.result = alu_res;
            st_d.flags  = alu_flags;
            st_d.wr     = alu_wr;
            st_d.sel    = dec.sel;
            st_d.mem    = dec.mem;
            st_d.cyc    = dec_cyc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign result      = st_q.result;
    assign flags_out   = st_q.flags;
    assign wr_en       = st_q.wr;
    assign src_sel     = st_q.sel;
    assign mem_operand = st_q.mem;
    assign cycles      = st_q.cyc;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int CYC_W        = 5,
    parameter int ACC_CYC      = 4,
    parameter int REG_CYC      = 8,
    parameter int MEM_CYC      = 16,
    parameter int MEM_TEST_CYC = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             acc_form,
    input logic [7:0]       opcode,
    input logic [3:0]       flags_in,
    input logic             out_valid,
    input logic [3:0]       flags_out,
    input logic             wr_en,
    input logic             mem_operand,
    input logic [CYC_W-1:0] cycles
);

    // R2: valid tracks the request one clock later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en));

    // R7: bit test never writes and forces H
    a_r7_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !acc_form && opcode[7:6] == 2'b01)
        |=> (!wr_en && flags_out[1] && !flags_out[2]));

    // R8: clear/set preserve every flag
    a_r8_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !acc_form && opcode[7])
        |=> (flags_out == $past(flags_in) && wr_en));

    // R9: accumulator forms force Z low and short timing
    a_r9_acc_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_form)
        |=> (!flags_out[3] && !mem_operand && cycles == CYC_W'(ACC_CYC)));

    // R10: memory operand lengthens the instruction
    a_r10_mem_longer: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mem_operand)
        |-> (cycles == CYC_W'(MEM_CYC) || cycles == CYC_W'(MEM_TEST_CYC)));
    a_r10_reg_short: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mem_operand)
        |-> (cycles == CYC_W'(REG_CYC) || cycles == CYC_W'(ACC_CYC)));

endmodule

bind bitop_unit bitop_unit_chk #(
    .CYC_W(CYC_W), .ACC_CYC(ACC_CYC), .REG_CYC(REG_CYC),
    .MEM_CYC(MEM_CYC), .MEM_TEST_CYC(MEM_TEST_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .acc_form    (acc_form),
    .opcode      (opcode),
    .flags_in    (flags_in),
    .out_valid   (out_valid),
    .flags_out   (flags_out),
    .wr_en       (wr_en),
    .mem_operand (mem_operand),
    .cycles      (cycles)
);

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       acc_form = 1'b0;
    logic [7:0] opcode = '0;
    logic [7:0] operand = '0;
    logic [3:0] flags_in = '0;
    logic       out_valid;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic       wr_en;
    logic [2:0] src_sel;
    logic       mem_operand;
    logic [4:0] cycles;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_form(acc_form),
        .opcode(opcode), .operand(operand), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .flags_out(flags_out),
        .wr_en(wr_en), .src_sel(src_sel), .mem_operand(mem_operand),
        .cycles(cycles)
    );

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Reference model built from the requirements (flags {Z,N,H,C}).
    function automatic void model(input logic [7:0] op, input logic acc,
        input logic [7:0] a, input logic [3:0] f,
        output logic [7:0] r, output logic [3:0] fo, output logic w,
        output logic [2:0] s, output logic m, output logic [4:0] cy,
        output string tag);
        int kind;
        int b;
        logic co;
        kind = acc ? int'(op[4:3]) : int'(op[7:3]);
        b  = int'(op[5:3]);
        r  = a; fo = f; w = 1'b1; co = 1'b0;
        s  = acc ? 3'd7 : op[2:0];
        m  = !acc && (op[2:0] == 3'd6);
        if (acc) tag = "R9";
        else if (op < 8'h20) tag = "R4";
        else if (op < 8'h30 || (op >= 8'h38 && op < 8'h40)) tag = "R5";
        else if (op < 8'h38) tag = "R6";
        else if (op < 8'h80) tag = "R7";
        else tag = "R8";
        if (acc || op < 8'h40) begin
            case (kind)
                0: begin r = (a << 1) | (a >> 7); co = a[7]; end
                1: begin r = (a >> 1) | (a << 7); co = a[0]; end
                2: begin r = (a << 1) | {7'd0, f[0]}; co = a[7]; end
                3: begin r = (a >> 1) | {f[0], 7'd0}; co = a[0]; end
                4: begin r = a << 1; co = a[7]; end
                5: begin r = (a >> 1) | (a & 8'h80); co = a[0]; end
                6: begin r = {a[3:0], a[7:4]}; co = 1'b0; end
                default: begin r = a >> 1; co = a[0]; end
            endcase
            fo = {(r == 8'h00) && !acc, 1'b0, 1'b0, co};
        end else if (op < 8'h80) begin
            w  = 1'b0;
            fo = {~a[b], 1'b0, 1'b1, f[0]};
        end else if (op < 8'hC0) begin
            r = a & ~(8'h01 << b);
        end else begin
            r = a | (8'h01 << b);
        end
        if (acc) cy = 5'd4;
        else if (!m) cy = 5'd8;
        else if (op[7:6] == 2'b01) cy = 5'd12;
        else cy = 5'd16;
    endfunction

    task automatic apply(input logic [7:0] op, input logic acc,
                         input logic [7:0] a, input logic [3:0] f);
        logic [7:0] er; logic [3:0] ef; logic ew; logic [2:0] es;
        logic em; logic [4:0] ec; string tag;
        model(op, acc, a, f, er, ef, ew, es, em, ec, tag);
        @(negedge clk);
        in_valid = 1'b1; acc_form = acc; opcode = op; operand = a; flags_in = f;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "out_valid", int'(out_valid), 1);
        check(tag, $sformatf("result op=%02h acc=%0d a=%02h", op, acc, a), int'(result), int'(er));
        check(tag, $sformatf("flags(R12) op=%02h acc=%0d a=%02h", op, acc, a), int'(flags_out), int'(ef));
        check(op[7:6] == 2'b01 && !acc ? "R7" : "R11", "wr_en", int'(wr_en), int'(ew));
        check("R3", "src_sel", int'(src_sel), int'(es));
        check("R3", "mem_operand", int'(mem_operand), int'(em));
        check(acc ? "R9" : "R10", "cycles", int'(cycles), int'(ec));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] held_r;
        logic [3:0] held_f;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "wr_en", int'(wr_en), 0);
        check("R1", "result", int'(result), 0);
        check("R1", "flags_out", int'(flags_out), 0);
        check("R1", "cycles", int'(cycles), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after release", int'(out_valid), 0);
        check("R1", "src_sel after release", int'(src_sel), 0);

        // Directed corners
        apply(8'h10, 1'b0, 8'h80, 4'b0001); // R4 RL carry in -> 01, C=1
        apply(8'h18, 1'b0, 8'h01, 4'b0000); // R4 RR -> 00, Z=1, C=1
        apply(8'h00, 1'b0, 8'h00, 4'b0001); // R4 RLC zero
        apply(8'h0E, 1'b0, 8'h01, 4'b0000); // R4 RRC memory -> 80
        apply(8'h2F, 1'b0, 8'h81, 4'b0000); // R5 SRA keeps sign -> C0
        apply(8'h27, 1'b0, 8'h80, 4'b0000); // R5 SLA -> 00, Z, C
        apply(8'h3F, 1'b0, 8'hFF, 4'b0000); // R5 SRL -> 7F
        apply(8'h37, 1'b0, 8'hF0, 4'b1111); // R6 SWAP -> 0F, clears C
        apply(8'h36, 1'b0, 8'h00, 4'b0001); // R6 SWAP zero on memory
        apply(8'h7F, 1'b0, 8'h7F, 4'b0001); // R7 test bit 7 clear -> Z
        apply(8'h46, 1'b0, 8'h01, 4'b0000); // R7 memory test, 12 ticks
        apply(8'h86, 1'b0, 8'hFF, 4'b1010); // R8 clear bit 0 on memory
        apply(8'hFF, 1'b0, 8'h00, 4'b0101); // R8 set bit 7
        apply(8'h07, 1'b1, 8'h00, 4'b1111); // R9 RLCA zero: Z forced low
        apply(8'h17, 1'b1, 8'h80, 4'b0000); // R9 RLA -> 00, Z=0, C=1
        apply(8'hFE, 1'b1, 8'h01, 4'b0001); // R9 ignores low bits: RR

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [7:0] op;
            logic ac;
            op = 8'($urandom);
            ac = ($urandom % 8) == 0;
            apply(op, ac, 8'($urandom), 4'($urandom));
        end

        // R2: idle cycle holds data, drops valid and write enable
        held_r = result;
        held_f = flags_out;
        @(negedge clk);
        check("R2", "idle out_valid", int'(out_valid), 0);
        check("R2", "idle wr_en", int'(wr_en), 0);
        check("R2", "idle result held", int'(result), int'(held_r));
        check("R2", "idle flags held", int'(flags_out), int'(held_f));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule